// File: doc/BRIEF.md
# Keyed-Start Watchdog Timer

A memory-mapped watchdog built around an up-counter. The counter advances on timer ticks (a strobe that marks each edge of a slow timer clock, nominally 32768 Hz), optionally thinned by a power-of-two prescaler. Software sets a reload value and arms the timeout by loading the counter. When the counter steps past all-ones, the block raises a one-cycle reset request, reloads the counter from the load register and keeps counting. To keep the system alive, software writes a new value to the trigger register, which reloads the counter.

Writes land in a per-register shadow stage. Each shadow stage mirrors a hand-over to the timer domain: the write counts as pending for a fixed number of timer ticks and only then reaches the live register. A status register shows which writes are still pending. The counter can be started or stopped only by an ordered pair of key words written to the run register. Any other pattern is discarded.

Top module: `wdt_top`

## Requirements
- R1: After reset the counter, load value, control and pending status all read 0, the counter is stopped, the run register reads 0 and `wdt_rst_o` is low.
- R2: Reading offset 0x00 returns the `REV` parameter in bits 7:0 and zeros above it. Offset 0x10 reads as zero.
- R3: Pending status at offset 0x34 has bit 0 for control (0x24), bit 1 for counter (0x28), bit 2 for load (0x2C), bit 3 for trigger (0x30) and bit 4 for run (0x48). A flag rises on the clock after the write and stays set for exactly `PEND_TICKS` timer ticks. The written value takes effect on the same edge at which the flag clears, and until then reads return the old value.
- R4: Writing 0x0000BBBB to the run register and then 0x00004444 as the next run-register write starts the counter. Bit 0 of the run register reads 1 while the counter runs.
- R5: Writing 0x0000AAAA and then 0x00005555 as the next run-register write stops the counter.
- R6: A run-register write that does not continue a valid pair returns the key checker to idle and leaves the run state unchanged.
- R7: While running, the counter increases by one per prescaled tick. While stopped it holds its value.
- R8: Control bit 5 enables the prescaler and bits 4:2 give PTV. When enabled, the counter steps once every 2^PTV ticks. When disabled, it steps on every tick.
- R9: A trigger write whose value differs from the previous trigger value copies the load register into the counter. A repeat of the same value has no effect.
- R10: A step from all-ones raises `wdt_rst_o` for exactly one clock and reloads the counter from the load register, and counting continues. With load = ~(N-1), the pulse comes on the N-th step.
- R11: A counter-register write sets the counter to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_tick | input | 1 | One-clock strobe per timer-clock edge |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_o | output | 1 | One-cycle reset request on counter overflow |

## Verification
The bench uses the defaults: a 32-bit counter, `PEND_TICKS` of 2 and `REV` of 0x31. A full-width counter can still reach overflow in a few ticks, because the bench loads the complement of a small tick count and fires a reload. The hold of two ticks keeps every pending window short enough to observe tick by tick. PTV set to 2 shows the division, including how the divider phase carries across the stop sequence.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 32;
    localparam int PTV_W  = 3;
    localparam int NREG   = 5;

    // pending-slot indices: bit positions of the status register
    localparam int IDX_CTRL  = 0;
    localparam int IDX_COUNT = 1;
    localparam int IDX_LOAD  = 2;
    localparam int IDX_TRIG  = 3;
    localparam int IDX_RUN   = 4;

    localparam logic [7:0] OFS_ID     = 8'h00;
    localparam logic [7:0] OFS_SYSCFG = 8'h10;
    localparam logic [7:0] OFS_CTRL   = 8'h24;
    localparam logic [7:0] OFS_COUNT  = 8'h28;
    localparam logic [7:0] OFS_LOAD   = 8'h2C;
    localparam logic [7:0] OFS_TRIG   = 8'h30;
    localparam logic [7:0] OFS_PEND   = 8'h34;
    localparam logic [7:0] OFS_RUN    = 8'h48;

    localparam logic [DATA_W-1:0] KEY_ON_A  = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_ON_B  = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_OFF_A = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_OFF_B = 32'h0000_5555;

    typedef enum logic [1:0] {
        KS_IDLE      = 2'd0,
        KS_ON_ARMED  = 2'd1,
        KS_OFF_ARMED = 2'd2
    } key_state_e;

    typedef struct packed {
        logic             pre_en;
        logic [PTV_W-1:0] ptv;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.pre_en = w[5];
        c.ptv    = w[4:2];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[5]   = c.pre_en;
        w[4:2] = c.ptv;
        return w;
    endfunction

    function automatic logic [7:0] slot_offset(input int idx);
        logic [7:0] o;
        case (idx)
            IDX_CTRL:  o = OFS_CTRL;
            IDX_COUNT: o = OFS_COUNT;
            IDX_LOAD:  o = OFS_LOAD;
            IDX_TRIG:  o = OFS_TRIG;
            default:   o = OFS_RUN;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/wdt_pend.sv
module wdt_pend #(
    parameter int NREG = 5,
    parameter int W    = 32,
    parameter int HOLD = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_i,
    input  logic [NREG-1:0]         wr_i,
    input  logic [W-1:0]            wdata_i,
    output logic [NREG-1:0]         busy_o,
    output logic [NREG-1:0]         apply_o,
    output logic [NREG-1:0][W-1:0]  shadow_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    for (genvar k = 0; k < NREG; k++) begin : g_slot
        logic [CW-1:0] left_q;
        logic [W-1:0]  data_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                left_q <= '0;
                data_q <= '0;
            end else if (wr_i[k]) begin
                left_q <= HOLD_C;
                data_q <= wdata_i;
            end else if (tick_i && left_q != '0) begin
                left_q <= left_q - ONE_C;
            end
        end

        assign busy_o[k]   = (left_q != '0);
        assign apply_o[k]  = tick_i && (left_q == ONE_C);
        assign shadow_o[k] = data_q;

        // R3: a write raises its pending flag on the next clock
        a_r3_flag_on_write: assert property (@(posedge clk) disable iff (rst)
            wr_i[k] |=> busy_o[k]);
        // R3: the flag drops on the edge at which the value is handed over
        a_r3_clear_on_apply: assert property (@(posedge clk) disable iff (rst)
            (apply_o[k] && !wr_i[k]) |=> !busy_o[k]);
    end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              apply_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              run_o
);
    key_state_e state_q, state_d;
    logic       run_q, run_d;

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (apply_i) begin
            state_d = KS_IDLE;
            case (state_q)
                KS_IDLE: begin
                    if (data_i == KEY_ON_A)       state_d = KS_ON_ARMED;
                    else if (data_i == KEY_OFF_A) state_d = KS_OFF_ARMED;
                end
                KS_ON_ARMED:  if (data_i == KEY_ON_B)  run_d = 1'b1;
                KS_OFF_ARMED: if (data_i == KEY_OFF_B) run_d = 1'b0;
                default: state_d = KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_IDLE;
            run_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    assign run_o = run_q;

    // R6: the first word of a pair never alters the run state
    a_r6_first_word_no_change: assert property (@(posedge clk) disable iff (rst)
        (apply_i && state_q == KS_IDLE) |=> (run_o == $past(run_o)));
    // R4: a completed start pair leaves the counter running
    a_r4_start_pair: assert property (@(posedge clk) disable iff (rst)
        (apply_i && state_q == KS_ON_ARMED && data_i == KEY_ON_B) |=> run_o);
    // R5: a completed stop pair leaves the counter stopped
    a_r5_stop_pair: assert property (@(posedge clk) disable iff (rst)
        (apply_i && state_q == KS_OFF_ARMED && data_i == KEY_OFF_B) |=> !run_o);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             en_i,
    input  logic [PTV_W-1:0] ptv_i,
    output logic             step_o
);
    localparam int DIV_W = (1 << PTV_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] lim;
    logic             hit;

    assign span   = {{DIV_W{1'b0}}, 1'b1} << ptv_i;
    assign lim    = DIV_W'(span - 1'b1);
    assign hit    = (div_q == lim);
    assign step_o = run_i && tick_i && (!en_i || hit);

    always_ff @(posedge clk) begin
        if (rst || !run_i || !en_i) begin
            div_q <= '0;
        end else if (tick_i) begin
            div_q <= hit ? '0 : div_q + 1'b1;
        end
    end

    // R8/R7: the counter only ever advances on a tick while running
    a_r8_step_needs_tick: assert property (@(posedge clk) disable iff (rst)
        step_o |-> (tick_i && run_i));
    // R8: a divided step restarts the phase count
    a_r8_phase_restart: assert property (@(posedge clk) disable iff (rst)
        (step_o && en_i) |=> (div_q == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 32,
    parameter int W     = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             cnt_wr_i,
    input  logic [W-1:0]     cnt_d_i,
    input  logic             load_wr_i,
    input  logic [W-1:0]     load_d_i,
    input  logic             trig_wr_i,
    input  logic [W-1:0]     trig_d_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] load_o,
    output logic [W-1:0]     trig_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, load_q;
    logic [W-1:0]     trig_q;
    logic             ovf_q;
    logic             trig_fire;

    assign trig_fire = trig_wr_i && (trig_d_i != trig_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            load_q <= '0;
            trig_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (load_wr_i) load_q <= load_d_i[CNT_W-1:0];
            if (trig_wr_i) trig_q <= trig_d_i;
            if (cnt_wr_i) begin
                cnt_q <= cnt_d_i[CNT_W-1:0];
            end else if (trig_fire) begin
                cnt_q <= load_q;
            end else if (step_i) begin
                if (cnt_q == CNT_MAX) begin
                    cnt_q <= load_q;
                    ovf_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign load_o = load_q;
    assign trig_o = trig_q;
    assign ovf_o  = ovf_q;

    // R10: the overflow pulse coincides with a reload from the load register
    a_r10_reload_on_pulse: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (cnt_q == $past(load_q)));
    // R7: with no step and no write, the counter holds
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !cnt_wr_i && !trig_fire) |=> $stable(cnt_q));
    // R9: repeating the trigger value leaves the counter alone
    a_r9_same_trigger: assert property (@(posedge clk) disable iff (rst)
        (trig_wr_i && trig_d_i == trig_q && !cnt_wr_i && !step_i) |=> $stable(cnt_q));
    // R11: a direct counter write wins over everything else
    a_r11_direct_write: assert property (@(posedge clk) disable iff (rst)
        cnt_wr_i |=> (cnt_q == $past(cnt_d_i[CNT_W-1:0])));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int         CNT_W      = 32,
    parameter int         PEND_TICKS = 2,
    parameter logic [7:0] REV        = 8'h31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_tick,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst_o
);
    logic [NREG-1:0]             wr_vec, busy, apply;
    logic [NREG-1:0][DATA_W-1:0] shadow;
    ctrl_t                       ctrl_q;
    logic                        run, step;
    logic [CNT_W-1:0]            cnt, load;
    logic [DATA_W-1:0]           trig;

    for (genvar k = 0; k < NREG; k++) begin : g_dec
        assign wr_vec[k] = bus_wr && (bus_addr == slot_offset(k));
    end

    wdt_pend #(.NREG(NREG), .W(DATA_W), .HOLD(PEND_TICKS)) u_pend (
        .clk(clk), .rst(rst), .tick_i(tmr_tick),
        .wr_i(wr_vec), .wdata_i(bus_wdata),
        .busy_o(busy), .apply_o(apply), .shadow_o(shadow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (apply[IDX_CTRL]) begin
            ctrl_q <= ctrl_unpack(shadow[IDX_CTRL]);
        end
    end

    wdt_keyseq u_keys (
        .clk(clk), .rst(rst),
        .apply_i(apply[IDX_RUN]), .data_i(shadow[IDX_RUN]),
        .run_o(run)
    );

    wdt_prescaler #(.PTV_W(PTV_W)) u_presc (
        .clk(clk), .rst(rst), .tick_i(tmr_tick), .run_i(run),
        .en_i(ctrl_q.pre_en), .ptv_i(ctrl_q.ptv), .step_o(step)
    );

    wdt_counter #(.CNT_W(CNT_W), .W(DATA_W)) u_cnt (
        .clk(clk), .rst(rst), .step_i(step),
        .cnt_wr_i(apply[IDX_COUNT]),  .cnt_d_i(shadow[IDX_COUNT]),
        .load_wr_i(apply[IDX_LOAD]),  .load_d_i(shadow[IDX_LOAD]),
        .trig_wr_i(apply[IDX_TRIG]),  .trig_d_i(shadow[IDX_TRIG]),
        .cnt_o(cnt), .load_o(load), .trig_o(trig), .ovf_o(wdt_rst_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_ID:    bus_rdata = {{(DATA_W-8){1'b0}}, REV};
            OFS_CTRL:  bus_rdata = ctrl_pack(ctrl_q);
            OFS_COUNT: bus_rdata = DATA_W'(cnt);
            OFS_LOAD:  bus_rdata = DATA_W'(load);
            OFS_TRIG:  bus_rdata = trig;
            OFS_PEND:  bus_rdata = DATA_W'(busy);
            OFS_RUN:   bus_rdata = DATA_W'(run);
            default:   bus_rdata = '0;
        endcase
    end

    // R10: the reset request never lasts two clocks without a fresh step
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |=> (!wdt_rst_o || $past(step)));
    // R3: the pending status only shows slots in the register map
    a_r3_status_width: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_PEND) |-> (bus_rdata[DATA_W-1:NREG] == '0));
endmodule

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmr_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wdt_top u_dut (
        .clk(clk), .rst(rst), .tmr_tick(tmr_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_rst_o(wdt_rst_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tmr_tick = 1'b1;
            @(negedge clk); tmr_tick = 1'b0;
        end
    endtask

    task automatic wr_apply(input logic [7:0] a, input logic [31:0] d);
        wr(a, d);
        ticks(2);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h28, v); chk("R1 counter", v, 32'h0);
        rd(8'h2C, v); chk("R1 load", v, 32'h0);
        rd(8'h24, v); chk("R1 control", v, 32'h0);
        rd(8'h34, v); chk("R1 pending", v, 32'h0);
        rd(8'h48, v); chk("R1 run", v, 32'h0);
        chk("R1 reset out", {31'b0, wdt_rst_o}, 32'h0);
        rd(8'h00, v); chk("R2 revision", v, 32'h31);
        rd(8'h10, v); chk("R2 sysconfig", v, 32'h0);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        wr(8'h2C, 32'h1234);
        rd(8'h34, v); chk("R3 load pending set", v, 32'h4);
        rd(8'h2C, v); chk("R3 load old while pending", v, 32'h0);
        ticks(1);
        rd(8'h34, v); chk("R3 pending after one tick", v, 32'h4);
        rd(8'h2C, v); chk("R3 load still old", v, 32'h0);
        ticks(1);
        rd(8'h34, v); chk("R3 pending cleared", v, 32'h0);
        rd(8'h2C, v); chk("R3 load taken", v, 32'h1234);
        wr(8'h24, 32'h0);
        rd(8'h34, v); chk("R3 control flag bit0", v, 32'h1);
        wr(8'h48, 32'h0);
        rd(8'h34, v); chk("R3 run flag bit4", v, 32'h11);
        ticks(2);
        rd(8'h34, v); chk("R3 both cleared", v, 32'h0);
    endtask

    task automatic t_trigger();
        logic [31:0] v;
        wr(8'h30, 32'h1);
        rd(8'h34, v); chk("R3 trigger flag bit3", v, 32'h8);
        ticks(2);
        rd(8'h28, v); chk("R9 new trigger reloads", v, 32'h1234);
        wr(8'h28, 32'h50);
        rd(8'h34, v); chk("R3 counter flag bit1", v, 32'h2);
        ticks(2);
        rd(8'h28, v); chk("R11 counter write", v, 32'h50);
        wr_apply(8'h30, 32'h1);
        rd(8'h28, v); chk("R9 same trigger ignored", v, 32'h50);
        wr_apply(8'h30, 32'h2);
        rd(8'h28, v); chk("R9 second trigger reloads", v, 32'h1234);
    endtask

    task automatic t_start_stop();
        logic [31:0] v;
        ticks(3);
        rd(8'h28, v); chk("R7 holds while stopped", v, 32'h1234);
        wr_apply(8'h48, 32'h0000BBBB);
        wr_apply(8'h48, 32'h00004444);
        rd(8'h48, v); chk("R4 running", v, 32'h1);
        rd(8'h28, v); chk("R7 no step before start edge", v, 32'h1234);
        ticks(3);
        rd(8'h28, v); chk("R7 counts per tick", v, 32'h1237);
        wr_apply(8'h48, 32'h0000AAAA);
        wr_apply(8'h48, 32'h00005555);
        rd(8'h48, v); chk("R5 stopped", v, 32'h0);
        rd(8'h28, v); chk("R7 steps during stop pair", v, 32'h123B);
        ticks(3);
        rd(8'h28, v); chk("R5 holds after stop", v, 32'h123B);
    endtask

    task automatic t_broken();
        logic [31:0] v;
        wr_apply(8'h48, 32'h0000BBBB);
        wr_apply(8'h48, 32'h00001234);
        wr_apply(8'h48, 32'h00004444);
        rd(8'h48, v); chk("R6 broken start stays stopped", v, 32'h0);
        rd(8'h28, v); chk("R6 counter unchanged", v, 32'h123B);
        wr_apply(8'h48, 32'h0000AAAA);
        wr_apply(8'h48, 32'h00004444);
        rd(8'h48, v); chk("R6 mixed pair stays stopped", v, 32'h0);
        wr_apply(8'h48, 32'h0000BBBB);
        wr_apply(8'h48, 32'h00004444);
        wr_apply(8'h48, 32'h0000AAAA);
        wr_apply(8'h48, 32'h0000BBBB);
        wr_apply(8'h48, 32'h00005555);
        rd(8'h48, v); chk("R6 broken stop keeps running", v, 32'h1);
        wr_apply(8'h48, 32'h0000AAAA);
        wr_apply(8'h48, 32'h00005555);
        rd(8'h48, v); chk("R5 stop after recovery", v, 32'h0);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        wr_apply(8'h24, 32'h28);
        rd(8'h24, v); chk("R8 control readback", v, 32'h28);
        wr_apply(8'h28, 32'd100);
        wr_apply(8'h48, 32'h0000BBBB);
        wr_apply(8'h48, 32'h00004444);
        ticks(3);
        rd(8'h28, v); chk("R8 no step before 4 ticks", v, 32'd100);
        ticks(1);
        rd(8'h28, v); chk("R8 step on 4th tick", v, 32'd101);
        ticks(4);
        rd(8'h28, v); chk("R8 second divided step", v, 32'd102);
        wr_apply(8'h48, 32'h0000AAAA);
        wr_apply(8'h48, 32'h00005555);
        rd(8'h28, v); chk("R8 divided step in stop pair", v, 32'd103);
        wr_apply(8'h24, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        int early = 0;
        wr_apply(8'h2C, ~(32'd5 - 32'd1));
        wr_apply(8'h30, 32'h3);
        rd(8'h28, v); chk("R10 armed value", v, 32'hFFFF_FFFB);
        wr_apply(8'h48, 32'h0000BBBB);
        wr_apply(8'h48, 32'h00004444);
        for (int i = 0; i < 4; i++) begin
            ticks(1);
            if (wdt_rst_o) early++;
        end
        chk("R10 no pulse before N steps", early, 0);
        rd(8'h28, v); chk("R10 at all-ones", v, 32'hFFFF_FFFF);
        ticks(1);
        chk("R10 pulse on Nth step", {31'b0, wdt_rst_o}, 32'h1);
        rd(8'h28, v); chk("R10 reloaded", v, 32'hFFFF_FFFB);
        @(negedge clk);
        chk("R10 pulse one clock", {31'b0, wdt_rst_o}, 32'h0);
        ticks(4);
        chk("R10 quiet before second wrap", {31'b0, wdt_rst_o}, 32'h0);
        ticks(1);
        chk("R10 keeps running, second pulse", {31'b0, wdt_rst_o}, 32'h1);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pending();
        t_trigger();
        t_start_stop();
        t_broken();
        t_prescale();
        t_overflow();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule